// File: doc/BRIEF.md
# Character-Row Video Address Generator

This block produces the character-memory address for a text screen of 25 rows by 40 columns, where every character row is painted on 8 consecutive raster lines. During the active part of a raster line a running counter walks across the 40 characters of the current row, one address per character clock. A row-start register keeps the address at which the current character row begins, so the same 40 addresses are replayed on each of the row's raster lines. A 3-bit raster-row counter tells the glyph lookup which line of the character cell is being drawn.

The row-start register stores only the upper address bits. Every row begins at a multiple of 40, which is also a multiple of 4, so the two lowest bits are always zero and are not kept. On the last raster line of a character row the register follows the running counter, so when that line ends it already holds the start of the next row. Whenever horizontal display is off, the counter is reloaded from the row-start register on each character clock. During blanking the address output therefore shows the address at which the next raster line will begin. A frame reset input returns the counter, the row-start register and the raster-row counter to zero at the top of each frame.

Top module: `vaddr_gen`

## Requirements
- R1: While `rst_n` is low, `vid_addr`, `line_start` and `raster_row` are all zero.
- R2: On each rising clock edge at which `hde` is high and `frame_rst` is low, `vid_addr` increases by one. After 40 active cycles that began at address S it reads S+40.
- R3: On each rising clock edge at which `hde` and `frame_rst` are low, `vid_addr` takes the value of `line_start`. One cycle into horizontal blanking the output therefore shows the start address of the next raster line.
- R4: When `raster_row` is not 7, `line_start` does not change, so every raster line of a character row receives the same 40 addresses.
- R5: When `raster_row` is 7 and `hde` is high, `line_start` follows the incremented address with its two low bits cleared. At the end of that line's active part it equals the row's start plus 40.
- R6: `raster_row` increases by one at each clock edge where `line_stb` is high, and wraps from 7 to 0.
- R7: A `frame_rst` high at a clock edge clears `vid_addr`, `line_start` and `raster_row` at that edge. It takes priority over `line_stb` and over the blanking reload.
- R8: Over a frame of 200 raster lines, each with 40 active cycles, addresses 0 to 999 each appear on exactly 8 raster lines, in increasing row order. During raster rows 0 to 6 of character row k, `line_start` reads 40·k: 0 in the first row, 40 in the second, 80 in the third.
- R9: The two low bits of `line_start` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hde | input | 1 | Horizontal display enable, high during the 40 active characters of a line |
| line_stb | input | 1 | One-cycle strobe at the end of each raster line |
| frame_rst | input | 1 | Synchronous clear at the start of a frame |
| vid_addr | output | 10 | Character-memory address |
| raster_row | output | 3 | Glyph line within the current character row |
| line_start | output | 10 | Start address of the next raster line (row-start register, low bits zero) |

## Verification
The main stimulus is a full frame of 200 lines, each with 40 active and 24 blanking cycles. The scoreboard expects every address of every line, and a second check looks at the output one cycle into blanking. The first frame follows a partial frame of 13 lines, so a frame reset that misses the row-start register or the raster counter shows up as wrong addresses from line 0 on. A frame reset that lands together with a line strobe tests the priority between the two. A second full frame that starts without a reset, directly after that clear, shows that the first character row replays correctly and that the row-7 hand-over does not depend on reset history.

// File: rtl/vag_pkg.sv
package vag_pkg;

  localparam int unsigned DEF_COLS       = 40;
  localparam int unsigned DEF_ROWS       = 25;
  localparam int unsigned DEF_SCAN_LINES = 8;
  localparam int unsigned DEF_DROP_BITS  = 2;

  // Number of bits needed to represent every value from 0 up to and including n.
  function automatic int unsigned width_for(int unsigned n);
    int unsigned bits;
    bits = 1;
    while ((64'd1 << bits) <= 64'(n)) bits++;
    return bits;
  endfunction

endpackage

// File: rtl/vag_raster_row.sv
module vag_raster_row #(
  parameter int unsigned SCAN_LINES = 8,
  parameter int unsigned ROW_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb,
  output logic [ROW_W-1:0] row_q,
  output logic             last_row
);

  localparam logic [ROW_W-1:0] LAST    = ROW_W'(SCAN_LINES - 1);
  localparam bit               IS_POW2 = ((1 << ROW_W) == SCAN_LINES);

  logic [ROW_W-1:0] row_inc;
  logic [ROW_W-1:0] row_d;

  generate
    if (IS_POW2) begin : g_natural_wrap
      assign row_inc = row_q + 1'b1;
    end else begin : g_forced_wrap
      assign row_inc = (row_q == LAST) ? '0 : row_q + 1'b1;
    end
  endgenerate

  assign last_row = (row_q == LAST);

  always_comb begin
    row_d = row_q;
    if (clr) begin
      row_d = '0;
    end else if (stb) begin
      row_d = row_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else begin
      row_q <= row_d;
    end
  end

  // R6: step and wrap of the glyph line counter
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && stb && row_q != LAST) |=> row_q == $past(row_q) + 1'b1);
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && stb && row_q == LAST) |=> row_q == '0);
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !stb) |=> $stable(row_q));
  // R7: frame clear wins over the strobe
  a_r7_row_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> row_q == '0);

endmodule

// File: rtl/vag_row_latch.sv
module vag_row_latch #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              follow,
  input  logic [ADDR_W-1:0] cnt_nx,
  input  logic [ADDR_W-1:0] cnt_q,
  output logic [LAT_W-1:0]  latch_q
);

  logic [LAT_W-1:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (clr) begin
      latch_d = '0;
    end else if (follow) begin
      latch_d = cnt_nx[ADDR_W-1 -: LAT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else begin
      latch_q <= latch_d;
    end
  end

  // R4: row start is frozen outside the last raster row
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !follow) |=> $stable(latch_q));
  // R5: on the last raster row it tracks the running counter's upper bits
  a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && follow) |=> latch_q == cnt_q[ADDR_W-1 -: LAT_W]);
  // R7: frame clear empties the row start
  a_r7_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> latch_q == '0);

endmodule

// File: rtl/vag_addr_counter.sv
module vag_addr_counter #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hde,
  input  logic [LAT_W-1:0]  latch_q,
  output logic [ADDR_W-1:0] cnt_q,
  output logic [ADDR_W-1:0] cnt_nx,
  output logic [ADDR_W-1:0] load_val
);

  localparam int unsigned DROP = ADDR_W - LAT_W;

  generate
    if (DROP == 0) begin : g_full_latch
      assign load_val = latch_q;
    end else begin : g_trimmed_latch
      assign load_val = {latch_q, {DROP{1'b0}}};
    end
  endgenerate

  always_comb begin
    cnt_nx = cnt_q;
    if (clr) begin
      cnt_nx = '0;
    end else if (hde) begin
      cnt_nx = cnt_q + 1'b1;
    end else begin
      cnt_nx = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  // R2: one address per active character clock
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hde) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3: blanking reloads from the row-start register
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hde) |=> cnt_q == {$past(latch_q), {DROP{1'b0}}});
  // R7: frame clear zeroes the counter
  a_r7_addr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

endmodule

// File: rtl/vaddr_gen.sv
module vaddr_gen #(
  parameter int unsigned COLS       = vag_pkg::DEF_COLS,
  parameter int unsigned ROWS       = vag_pkg::DEF_ROWS,
  parameter int unsigned SCAN_LINES = vag_pkg::DEF_SCAN_LINES,
  parameter int unsigned DROP_BITS  = vag_pkg::DEF_DROP_BITS,
  parameter int unsigned ADDR_W     = vag_pkg::width_for(COLS * ROWS),
  parameter int unsigned ROW_W      = $clog2(SCAN_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hde,
  input  logic              line_stb,
  input  logic              frame_rst,
  output logic [ADDR_W-1:0] vid_addr,
  output logic [ROW_W-1:0]  raster_row,
  output logic [ADDR_W-1:0] line_start
);

  localparam int unsigned LAT_W = ADDR_W - DROP_BITS;

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_nx;
  logic [ADDR_W-1:0] load_val;
  logic [LAT_W-1:0]  latch_q;
  logic [ROW_W-1:0]  row_q;
  logic              last_row;
  logic              follow;

  assign follow = last_row & hde;

  vag_raster_row #(
    .SCAN_LINES (SCAN_LINES),
    .ROW_W      (ROW_W)
  ) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (frame_rst),
    .stb      (line_stb),
    .row_q    (row_q),
    .last_row (last_row)
  );

  vag_row_latch #(
    .ADDR_W (ADDR_W),
    .LAT_W  (LAT_W)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (frame_rst),
    .follow  (follow),
    .cnt_nx  (cnt_nx),
    .cnt_q   (cnt_q),
    .latch_q (latch_q)
  );

  vag_addr_counter #(
    .ADDR_W (ADDR_W),
    .LAT_W  (LAT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (frame_rst),
    .hde      (hde),
    .latch_q  (latch_q),
    .cnt_q    (cnt_q),
    .cnt_nx   (cnt_nx),
    .load_val (load_val)
  );

  assign vid_addr   = cnt_q;
  assign raster_row = row_q;
  assign line_start = load_val;

  // R1: outputs sit at zero while reset is held
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (vid_addr == '0 && raster_row == '0 && line_start == '0);
    end
  end

  // R4 / R3: during blanking of a non-final row the output repeats the row start
  a_r4_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_rst && !hde && !last_row) |=> vid_addr == $past(line_start));

endmodule

// File: tb/tb_vaddr_gen.sv
`timescale 1ns/1ps
module tb_vaddr_gen;

  logic       clk;
  logic       rst_n;
  logic       hde;
  logic       line_stb;
  logic       frame_rst;
  logic [9:0] vid_addr;
  logic [2:0] raster_row;
  logic [9:0] line_start;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_q[$];

  vaddr_gen dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hde        (hde),
    .line_stb   (line_stb),
    .frame_rst  (frame_rst),
    .vid_addr   (vid_addr),
    .raster_row (raster_row),
    .line_start (line_start)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected address per active character cycle (R8 scoreboard)
  always @(negedge clk) begin
    #1;
    if (rst_n && hde) begin
      if (exp_q.size() == 0) begin
        check("R8 active cycle with empty scoreboard", int'(vid_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check("R8 R2 address sequence", int'(vid_addr), e);
      end
    end
  end

  // Driver for one 64-cycle raster line; entered and left on a falling edge
  task automatic run_line(input int ln);
    int r;
    int l;
    int st;
    int nx;
    r  = ln / 8;
    l  = ln % 8;
    st = 40 * r;
    nx = (l == 7) ? st + 40 : st;
    check("R6 raster row at line start", int'(raster_row), l);
    check("R3 address before active part", int'(vid_addr), st);
    for (int c = 0; c < 40; c++) exp_q.push_back(st + c);
    hde = 1'b1;
    repeat (40) @(negedge clk);
    hde = 1'b0;
    #1;
    check("R2 address after 40 active cycles", int'(vid_addr), st + 40);
    if (l == 7) check("R5 row start moved on last raster row", int'(line_start), st + 40);
    else        check("R4 R8 row start held", int'(line_start), st);
    @(negedge clk);
    #1;
    check("R3 blanking shows next line start", int'(vid_addr), nx);
    check("R9 row start low bits zero", int'(line_start[1:0]), 0);
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
    #1;
    check("R6 raster row after strobe", int'(raster_row), (l + 1) % 8);
    repeat (22) @(negedge clk);
  endtask

  task automatic run_frame(input int nlines, input bit with_rst);
    if (with_rst) begin
      frame_rst = 1'b1;
      @(negedge clk);
      frame_rst = 1'b0;
      #1;
      check("R7 address cleared", int'(vid_addr), 0);
      check("R7 row start cleared", int'(line_start), 0);
      check("R7 raster row cleared", int'(raster_row), 0);
      @(negedge clk);
    end
    for (int ln = 0; ln < nlines; ln++) run_line(ln);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    hde       = 1'b0;
    line_stb  = 1'b0;
    frame_rst = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset address", int'(vid_addr), 0);
    check("R1 reset raster row", int'(raster_row), 0);
    check("R1 reset row start", int'(line_start), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Partial frame leaves the row start and raster row non-zero
    run_frame(13, 1'b1);
    // Full frame after a frame reset
    run_frame(200, 1'b1);
    check("R8 scoreboard drained after frame", exp_q.size(), 0);

    // Partial frame, then frame reset together with a line strobe
    run_frame(13, 1'b1);
    frame_rst = 1'b1;
    line_stb  = 1'b1;
    @(negedge clk);
    frame_rst = 1'b0;
    line_stb  = 1'b0;
    #1;
    check("R7 reset beats strobe on raster row", int'(raster_row), 0);
    check("R7 reset beats reload on address", int'(vid_addr), 0);
    check("R7 reset clears row start", int'(line_start), 0);
    @(negedge clk);
    run_frame(200, 1'b0);
    check("R8 scoreboard drained after second frame", exp_q.size(), 0);

    finish_run();
  end

endmodule